// File: doc/BRIEF.md
# Token-Passing Serial Event Readout Controller

This block is the readout engine of one front-end chip in a chain of chips that share a single serial data line. The chips take turns on that line by handing a token from one to the next. While this chip holds the token, it drives the line and sends its stored events. Each event record comes from a local event RAM. When the last bit has gone out, it passes the token downstream. Up to 256 chips can sit on one line, because every event frame carries an 8-bit chip identifier.

On an accepted token the block captures the number of stored events, from 0 to 16. It sends that count as a short header. It then reads the RAM from address 0 upward and sends each event as one frame: the chip identifier, then the RAM word. Bits go out MSB first. A chip with no events sends nothing and passes the token one clock later, so an empty chip never stalls the chain. After every readout, the end-of-readout flag stays high until the next token is accepted, and the RAM read address is back at 0.

Top module: `token_readout_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `sdata`, `tx_active`, `token_out` and `eor` are 0, and `ram_addr` is 0.
- R2: If `token_in` is high at a clock edge while the block is idle and `ev_count` is 0, then in the next cycle `token_out` is high and `tx_active` stays low.
- R3: If `token_in` is high at an edge while the block is idle and the count is not 0, then from the next cycle the block holds `tx_active` high. It first sends the 5-bit event count on `sdata`, MSB first, one bit per cycle.
- R4: Each event frame is 34 bits, sent MSB first: the 8-bit `chip_id`, then the 26-bit RAM word. The RAM word is packed as bunch-crossing id [25:14], gain range [13], trigger status [12] and charge [11:0].
- R5: Events are sent in RAM address order 0, 1, ... N-1, and the frames follow each other with no gap. `ram_rdata` is taken as valid in the same cycle that `ram_addr` is presented.
- R6: `tx_active` is high for exactly 5 + 34·N consecutive cycles per readout. `sdata` is 0 whenever `tx_active` is low.
- R7: `token_out` is a one-cycle pulse in the cycle right after the last bit of the last event. It is never high while `tx_active` is high.
- R8: When a readout finishes, including a readout with no events, `eor` goes high and stays high until the next token is accepted. While `eor` is high, `ram_addr` is 0.
- R9: A `token_in` pulse that arrives during a transfer is ignored. The frames and the single `token_out` pulse are unchanged.
- R10: An `ev_count` value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| token_in | input | 1 | Token from the upstream chip (pulse) |
| chip_id | input | 8 | Identifier of this chip, placed in every frame |
| ev_count | input | 5 | Number of events stored in the event RAM |
| ram_addr | output | 4 | Event RAM read address |
| ram_rdata | input | 26 | Event RAM read data {bcid, gain, trig, charge} |
| sdata | output | 1 | Serial data, 0 when not transmitting |
| tx_active | output | 1 | High while this chip drives the line |
| token_out | output | 1 | Token to the downstream chip (one-cycle pulse) |
| eor | output | 1 | End of readout, held until the next token |

## Verification
The bench targets these corner cases:

- **Empty chip.** A design that sent a header for zero events, or passed the token late, would change the line or shift the `token_out` cycle.
- **Full memory and oversized count.** Sixteen events and a count of 20 expose a wrapping address or a missing clamp. Either fault shows up as a wrong header or extra frames.
- **Second token mid-transfer.** A design that accepted it would restart the header or emit two tokens.
- **Frame boundaries.** A one-event readout and back-to-back frames catch an off-by-one in the bit counter or a stale RAM word. Either fault shows up as misaligned bits against the reference queue.

// File: rtl/token_readout_ctrl.sv
module token_readout_ctrl #(
  parameter int ID_W     = 8,
  parameter int BCID_W   = 12,
  parameter int CHARGE_W = 12,
  parameter int DEPTH    = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int REC_W   = BCID_W + 2 + CHARGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              token_in,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [CNT_W-1:0]  ev_count,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [REC_W-1:0]  ram_rdata,
  output logic              sdata,
  output logic              tx_active,
  output logic              token_out,
  output logic              eor
);
  localparam int FRM_W = ID_W + REC_W;
  localparam int BIT_W = $clog2((FRM_W > CNT_W) ? FRM_W : CNT_W);

  typedef enum logic [1:0] {IDLE, HDR, EVT} st_t;

  st_t               st;
  logic [FRM_W-1:0]  shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  left;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt_in;

  assign cnt_in    = (ev_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : ev_count;
  assign tx_active = (st != IDLE);
  assign sdata     = tx_active & shreg[FRM_W-1];
  assign ram_addr  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      left      <= '0;
      ptr       <= '0;
      token_out <= 1'b0;
      eor       <= 1'b0;
    end else begin
      token_out <= 1'b0;
      case (st)
        IDLE: begin
          if (token_in) begin
            eor <= 1'b0;
            if (cnt_in == '0) begin
              token_out <= 1'b1;
              eor       <= 1'b1;
            end else begin
              st     <= HDR;
              shreg  <= {cnt_in, {(FRM_W-CNT_W){1'b0}}};
              bitcnt <= BIT_W'(CNT_W - 1);
              left   <= cnt_in;
            end
          end
        end
        default: begin
          if (bitcnt != '0) begin
            shreg  <= {shreg[FRM_W-2:0], 1'b0};
            bitcnt <= bitcnt - 1'b1;
          end else if (st == EVT && left == '0) begin
            st        <= IDLE;
            shreg     <= '0;
            ptr       <= '0;
            token_out <= 1'b1;
            eor       <= 1'b1;
          end else begin
            st     <= EVT;
            shreg  <= {chip_id, ram_rdata};
            bitcnt <= BIT_W'(FRM_W - 1);
            left   <= left - 1'b1;
            ptr    <= ptr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module token_readout_ctrl_chk #(
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              token_in,
  input logic [CNT_W-1:0]  ev_count,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              sdata,
  input logic              tx_active,
  input logic              token_out,
  input logic              eor
);
  assert_quiet_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !sdata);

  assert_tok_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |=> !token_out);

  assert_tok_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    token_out |-> !tx_active);

  assert_addr_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eor |-> (!tx_active && ram_addr == '0));

  assert_empty_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (token_in && !tx_active && ev_count == '0) |=> (token_out && !tx_active && eor));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (token_in && !tx_active && ev_count != '0) |=> (tx_active && !eor && !token_out));
endmodule

bind token_readout_ctrl token_readout_ctrl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .token_in(token_in), .ev_count(ev_count),
  .ram_addr(ram_addr), .sdata(sdata), .tx_active(tx_active),
  .token_out(token_out), .eor(eor)
);

// File: tb/token_readout_ctrl_tb_top.sv
module token_readout_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        token_in = 1'b0;
  logic [7:0]  chip_id = 8'hA5;
  logic [4:0]  ev_count = '0;
  logic [3:0]  ram_addr;
  logic [25:0] ram_rdata;
  logic        sdata, tx_active, token_out, eor;
  logic [25:0] mem [16];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit running = 0;
  string phase = "";

  bit q[$];
  bit etok = 0;
  bit eeor = 0;
  int tok_seen = 0;
  int tx_cycles = 0;

  always #10 clk = ~clk;
  assign ram_rdata = mem[ram_addr];

  token_readout_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .token_in(token_in), .chip_id(chip_id),
    .ev_count(ev_count), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .sdata(sdata), .tx_active(tx_active), .token_out(token_out), .eor(eor)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] cycle %0d: actual=%0d expected=%0d", tag, phase, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      etok = 0;
      eeor = 0;
    end else begin
      etok = 0;
      if (q.size() > 0) begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          etok = 1;
          eeor = 1;
        end
      end else if (token_in) begin
        int n;
        eeor = 0;
        n = (ev_count > 16) ? 16 : int'(ev_count);
        if (n == 0) begin
          etok = 1;
          eeor = 1;
        end else begin
          for (int b = 4; b >= 0; b--) q.push_back(n[b]);
          for (int e = 0; e < n; e++) begin
            logic [33:0] w;
            w = {chip_id, mem[e]};
            for (int b = 33; b >= 0; b--) q.push_back(w[b]);
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (token_out) tok_seen++;
    if (tx_active) tx_cycles++;
    if (running) begin
      chk("R3 R4 R5 sdata", sdata, (q.size() > 0) ? int'(q[0]) : 0);
      chk("R6 tx_active", tx_active, (q.size() > 0) ? 1 : 0);
      chk("R2 R7 token_out", token_out, etok);
      chk("R8 eor", eor, eeor);
      if (q.size() == 0) chk("R8 ram_addr idle", ram_addr, 0);
    end
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic readout(input int n, input bit busy_tok, input string ph);
    phase = ph;
    ev_count = 5'(n);
    for (int i = 0; i < 16; i++) mem[i] = 26'($urandom);
    chip_id = 8'($urandom);
    tok_seen = 0;
    tx_cycles = 0;
    @(negedge clk);
    token_in = 1'b1;
    @(negedge clk);
    token_in = 1'b0;
    if (busy_tok) begin
      repeat (12) @(negedge clk);
      token_in = 1'b1;
      @(negedge clk);
      token_in = 1'b0;
    end
    for (int k = 0; k < 700 && (tx_active || token_out); k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 sdata in reset", sdata, 0);
    chk("R1 tx_active in reset", tx_active, 0);
    chk("R1 token_out in reset", token_out, 0);
    chk("R1 eor in reset", eor, 0);
    chk("R1 ram_addr in reset", ram_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    chk("R1 idle after reset", tx_active | token_out | eor | sdata, 0);

    readout(3, 0, "three events");
    chk("R6 active length 3", tx_cycles, 5 + 34 * 3);
    chk("R7 one token 3", tok_seen, 1);

    readout(0, 0, "R2 empty chip");
    chk("R2 no transmit", tx_cycles, 0);
    chk("R2 one token", tok_seen, 1);

    readout(1, 0, "single event");
    chk("R6 active length 1", tx_cycles, 5 + 34);

    readout(16, 0, "full memory");
    chk("R6 active length 16", tx_cycles, 5 + 34 * 16);

    readout(20, 0, "R10 saturate");
    chk("R10 clamped length", tx_cycles, 5 + 34 * 16);

    readout(5, 1, "R9 busy token");
    chk("R9 length unchanged", tx_cycles, 5 + 34 * 5);
    chk("R9 single token", tok_seen, 1);

    readout(0, 0, "R2 empty again");
    readout(2, 0, "two events");
    chk("R7 one token 2", tok_seen, 1);

    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule